// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache that sits between a processor that issues single-byte loads and stores and a slower byte-wide backing memory. It holds 64 bytes in 16 sets. Each set has two ways, and each way holds one 2-byte line. Every request is looked up in the cache and is answered with the data and a hit flag.

Stores that hit stay in the cache and mark the line dirty. A miss allocates a line, whether it was a load or a store. When the chosen victim is dirty, its two bytes are first written to memory, and the new line is then fetched as two byte reads. A store miss merges its byte into the freshly fetched line.

The processor side offers one request at a time. It is accepted while `req_ready` is high and answered by a one-cycle `resp_valid` pulse. The memory side is a valid/ready port that carries one byte per accepted transfer. Read data is returned combinationally in the cycle the transfer is accepted.

Top module: `wbc_cache`

## Requirements
- R1: A request address splits into a tag in bits [7:5], a set index in bits [4:1] and a byte offset in bit [0]. Addresses with different index bits never disturb each other's lines.
- R2: A request hits only when one of the two ways of the indexed set is valid and its stored tag equals the address tag. `resp_hit` is 1 on a hit and 0 on a miss.
- R3: A read hit returns the stored byte and makes no memory transfer.
- R4: A write hit replaces the addressed byte and marks the line dirty, with no memory transfer. `resp_rdata` echoes the written byte.
- R5: A miss fetches the line as two memory reads (`mem_write`=0) at {tag,index,0} and then {tag,index,1}. It then responds with `resp_hit`=0 and the requested byte.
- R6: The victim on a miss is an invalid way, taking way 0 when both ways are invalid. When both ways are valid, the victim is the least recently used way, where every hit and every fill counts as a use.
- R7: A dirty victim is written to memory (`mem_write`=1) as two byte writes, at {old tag,index,0} and then {old tag,index,1}, before any fetch read is issued.
- R8: A clean victim is dropped without any memory write.
- R9: A write miss fetches the line, then merges the written byte and leaves the line dirty.
- R10: Reset empties the cache and clears all valid, dirty and recency state. After reset, `req_ready`=1, `resp_valid`=0 and `mem_valid`=0, and the first access to any address misses.
- R11: `req_ready` is high only while the block is idle. Each accepted request gets exactly one single-cycle response. A hit responds in the second cycle after the accepting edge.
- R12: While `mem_valid` is high and `mem_ready` is low, the memory request (address, direction, write data) holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | 8 | Load data, or echoed store data |
| mem_valid | output | 1 | Memory transfer requested |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_write | output | 1 | 1 = write-back byte, 0 = fetch byte |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Write-back data |
| mem_rdata | input | 8 | Fetch data, valid with the accepted read |

## Verification
The bench targets victim choice in a full set. A design with inverted recency would evict a line that was just used, and the bench would then see a miss where a hit was expected. It drives dirty evictions under a stalling memory. A block that fetched before writing back, wrote a stale byte, or let the address move during a stall would show up as a wrong or out-of-order memory transfer. Store misses are followed by reads of both bytes of the line, which catches a merge that overwrote the fetched neighbour or lost the dirty mark. A dropped dirty mark surfaces as a missing write-back later on. A mid-run reset must turn a known hit back into a miss.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 4;
  localparam int OFF_W  = 1;
  localparam int DATA_W = 8;
  localparam int WAYS   = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int BEATS  = 1 << OFF_W;
  localparam int WAY_W  = $clog2(WAYS);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [WAY_W-1:0]  way_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WBACK, ST_REFILL, ST_RESPOND
  } state_t;

  function automatic tag_t tag_of(addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic idx_t idx_of(addr_t a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic off_t off_of(addr_t a);
    return a[OFF_W-1:0];
  endfunction

  function automatic addr_t join_addr(tag_t t, idx_t i, off_t o);
    return {t, i, o};
  endfunction

  // lowest-numbered invalid way wins; with every way valid the recency pick is used
  function automatic way_t victim_pick(logic [WAYS-1:0] valid, way_t lru);
    way_t pick;
    pick = lru;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) pick = way_t'(w);
    end
    return pick;
  endfunction
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
  import wbc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  idx_t                        idx,
  input  tag_t                        cmp_tag,
  input  logic                        fill_en,
  input  logic                        dirty_set,
  input  logic                        lru_upd,
  input  way_t                        acc_way,
  output logic [WAYS-1:0]             way_valid,
  output logic [WAYS-1:0]             way_dirty,
  output logic [WAYS-1:0]             way_hit,
  output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  output way_t                        lru_way
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] valid_q;
    logic [SETS-1:0] dirty_q;
    tag_t            tag_q [SETS];
    logic            sel;

    assign sel = (acc_way == way_t'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (fill_en && sel) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (dirty_set && sel) begin
        dirty_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && sel) tag_q[idx] <= cmp_tag;
    end

    assign way_valid[w] = valid_q[idx];
    assign way_dirty[w] = dirty_q[idx];
    assign way_tag[w]   = tag_q[idx];
    // valid gates the tag compare
    assign way_hit[w]   = valid_q[idx] && (tag_q[idx] == cmp_tag);
  end

  // one bit per set naming the way to evict next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else if (lru_upd) lru_q[idx] <= ~acc_way;
  end

  assign lru_way = lru_q[idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store
  import wbc_pkg::*;
(
  input  logic                        clk,
  input  idx_t                        idx,
  input  off_t                        rd_off,
  input  logic                        wr_en,
  input  way_t                        wr_way,
  input  off_t                        wr_off,
  input  byte_t                       wr_data,
  output logic [WAYS-1:0][DATA_W-1:0] rd_data
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    byte_t line_q [SETS][BEATS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == way_t'(w))) line_q[idx][wr_off] <= wr_data;
    end

    assign rd_data[w] = line_q[idx][rd_off];
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  addr_t                       req_addr,
  input  byte_t                       req_wdata,
  output logic                        req_ready,
  output logic                        resp_valid,
  output logic                        resp_hit,
  output byte_t                       resp_rdata,
  output logic                        mem_valid,
  output logic                        mem_write,
  output addr_t                       mem_addr,
  output byte_t                       mem_wdata,
  input  logic                        mem_ready,
  input  byte_t                       mem_rdata,
  output idx_t                        cur_idx,
  output tag_t                        cur_tag,
  output off_t                        rd_off,
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0]             way_dirty,
  input  logic [WAYS-1:0]             way_hit,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  way_t                        lru_way,
  input  logic [WAYS-1:0][DATA_W-1:0] rd_data,
  output logic                        fill_en,
  output logic                        dirty_set,
  output logic                        lru_upd,
  output way_t                        sel_way,
  output logic                        wr_en,
  output off_t                        wr_off,
  output byte_t                       wr_data,
  output logic                        ev_lookup_hit,
  output logic                        ev_lookup_miss,
  output logic                        ev_wb_done,
  output logic                        ev_fill_done
);
  state_t state_q;
  logic   wr_q;
  addr_t  addr_q;
  byte_t  data_q;
  way_t   way_q;
  logic   hit_q;
  off_t   beat_q;

  way_t   hit_way;
  way_t   victim;
  logic   any_hit;
  logic   beat_last;
  logic   victim_dirty;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = way_t'(w);
    end
  end

  assign any_hit      = |way_hit;
  assign victim       = victim_pick(way_valid, lru_way);
  assign victim_dirty = way_valid[victim] && way_dirty[victim];
  assign beat_last    = (beat_q == off_t'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      way_q   <= '0;
      hit_q   <= 1'b0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          addr_q  <= req_addr;
          data_q  <= req_wdata;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          hit_q   <= any_hit;
          way_q   <= any_hit ? hit_way : victim;
          beat_q  <= '0;
          state_q <= any_hit ? ST_RESPOND : (victim_dirty ? ST_WBACK : ST_REFILL);
        end
        ST_WBACK: if (mem_ready) begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) state_q <= ST_REFILL;
        end
        ST_REFILL: if (mem_ready) begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) state_q <= ST_RESPOND;
        end
        ST_RESPOND: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_idx    = idx_of(addr_q);
  assign cur_tag    = tag_of(addr_q);
  assign rd_off     = (state_q == ST_WBACK) ? beat_q : off_of(addr_q);
  assign sel_way    = way_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign resp_valid = (state_q == ST_RESPOND);
  assign resp_hit   = resp_valid && hit_q;
  assign resp_rdata = wr_q ? data_q : rd_data[way_q];

  assign mem_valid  = (state_q == ST_WBACK) || (state_q == ST_REFILL);
  assign mem_write  = (state_q == ST_WBACK);
  assign mem_addr   = mem_write ? join_addr(way_tag[way_q], cur_idx, beat_q)
                                : join_addr(cur_tag, cur_idx, beat_q);
  assign mem_wdata  = mem_write ? rd_data[way_q] : '0;

  assign wr_en      = ((state_q == ST_REFILL) && mem_ready) || (resp_valid && wr_q);
  assign wr_off     = (state_q == ST_REFILL) ? beat_q : off_of(addr_q);
  assign wr_data    = (state_q == ST_REFILL) ? mem_rdata : data_q;
  assign fill_en    = (state_q == ST_REFILL) && mem_ready && beat_last;
  assign dirty_set  = resp_valid && wr_q;
  assign lru_upd    = resp_valid;

  assign ev_lookup_hit  = (state_q == ST_LOOKUP) && any_hit;
  assign ev_lookup_miss = (state_q == ST_LOOKUP) && !any_hit;
  assign ev_wb_done     = (state_q == ST_WBACK) && mem_ready && beat_last;
  assign ev_fill_done   = fill_en;
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [WAYS-1:0]             way_valid;
  logic [WAYS-1:0]             way_dirty;
  logic [WAYS-1:0]             way_hit;
  logic [WAYS-1:0][TAG_W-1:0]  way_tag;
  logic [WAYS-1:0][DATA_W-1:0] rd_data;
  way_t                        lru_way;
  idx_t                        cur_idx;
  tag_t                        cur_tag;
  off_t                        rd_off;
  off_t                        wr_off;
  byte_t                       wr_data;
  way_t                        sel_way;
  logic                        fill_en;
  logic                        dirty_set;
  logic                        lru_upd;
  logic                        wr_en;
  logic                        ev_lookup_hit;
  logic                        ev_lookup_miss;
  logic                        ev_wb_done;
  logic                        ev_fill_done;

  wbc_tag_store u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (cur_idx),
    .cmp_tag   (cur_tag),
    .fill_en   (fill_en),
    .dirty_set (dirty_set),
    .lru_upd   (lru_upd),
    .acc_way   (sel_way),
    .way_valid (way_valid),
    .way_dirty (way_dirty),
    .way_hit   (way_hit),
    .way_tag   (way_tag),
    .lru_way   (lru_way)
  );

  wbc_data_store u_data (
    .clk     (clk),
    .idx     (cur_idx),
    .rd_off  (rd_off),
    .wr_en   (wr_en),
    .wr_way  (sel_way),
    .wr_off  (wr_off),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  wbc_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .req_ready      (req_ready),
    .resp_valid     (resp_valid),
    .resp_hit       (resp_hit),
    .resp_rdata     (resp_rdata),
    .mem_valid      (mem_valid),
    .mem_write      (mem_write),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ready      (mem_ready),
    .mem_rdata      (mem_rdata),
    .cur_idx        (cur_idx),
    .cur_tag        (cur_tag),
    .rd_off         (rd_off),
    .way_valid      (way_valid),
    .way_dirty      (way_dirty),
    .way_hit        (way_hit),
    .way_tag        (way_tag),
    .lru_way        (lru_way),
    .rd_data        (rd_data),
    .fill_en        (fill_en),
    .dirty_set      (dirty_set),
    .lru_upd        (lru_upd),
    .sel_way        (sel_way),
    .wr_en          (wr_en),
    .wr_off         (wr_off),
    .wr_data        (wr_data),
    .ev_lookup_hit  (ev_lookup_hit),
    .ev_lookup_miss (ev_lookup_miss),
    .ev_wb_done     (ev_wb_done),
    .ev_fill_done   (ev_fill_done)
  );
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk
  import wbc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              ev_lookup_hit,
  input logic              ev_lookup_miss,
  input logic              ev_wb_done,
  input logic              ev_fill_done
);
  // R11
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lookup_hit |=> resp_valid && resp_hit && !mem_valid);

  // R5
  miss_goes_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lookup_miss |=> mem_valid && !resp_valid);

  // R7
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> mem_valid && !mem_write);

  // R5
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> resp_valid && !resp_hit);
endmodule

bind wbc_cache wbc_cache_chk u_chk (.*);

// File: tb/wbc_cache_test.sv
module wbc_cache_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       resp_valid;
  logic       resp_hit;
  logic [7:0] resp_rdata;
  logic       mem_valid;
  logic       mem_ready = 1'b1;
  logic       mem_write;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;

  logic [7:0] mem_img [256];
  assign mem_rdata = mem_img[mem_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  wbc_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit stall_mode = 0;
  bit busy = 0;

  typedef struct { bit we; logic [7:0] a; logic [7:0] d; } mop_t;
  mop_t exp_q[$];

  // reference model: per set and way
  bit         mv   [16][2];
  bit         md   [16][2];
  logic [2:0] mt   [16][2];
  logic [7:0] mdat [16][2][2];
  int         mvict[16];

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 16; s++) begin
      mvict[s] = 0;
      for (int k = 0; k < 2; k++) begin
        mv[s][k] = 0;
        md[s][k] = 0;
      end
    end
  endtask

  // memory responder and per-cycle protocol comparison
  initial begin
    mop_t e;
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (mem_valid && mem_ready) begin
          if (exp_q.size() == 0) begin
            chk(0, "R8", "unexpected memory transfer", {mem_write, mem_addr}, 0);
          end else begin
            e = exp_q.pop_front();
            chk(mem_write == e.we && mem_addr == e.a && (!e.we || mem_wdata == e.d),
                e.we ? "R7" : "R5", "memory transfer {we,addr,data}",
                {mem_write, mem_addr, mem_wdata}, {e.we, e.a, e.we ? e.d : mem_wdata});
            if (mem_write) mem_img[mem_addr] = mem_wdata;
          end
        end
        if (resp_valid && !busy) chk(0, "R11", "response without request", 1, 0);
      end
    end
  end

  task automatic access(bit we, logic [7:0] a, logic [7:0] d, string rq);
    int idx, tg, off, w, v, n;
    bit hit;
    logic [7:0] ed;
    idx = int'(a[4:1]);
    tg  = int'(a[7:5]);
    off = int'(a[0]);
    w   = -1;
    for (int k = 0; k < 2; k++) if (mv[idx][k] && mt[idx][k] == tg[2:0]) w = k;
    hit = (w >= 0);
    if (!hit) begin
      v = !mv[idx][0] ? 0 : (!mv[idx][1] ? 1 : mvict[idx]);
      if (mv[idx][v] && md[idx][v]) begin
        for (int b = 0; b < 2; b++)
          exp_q.push_back('{1'b1, {mt[idx][v], idx[3:0], b[0]}, mdat[idx][v][b]});
      end
      for (int b = 0; b < 2; b++) begin
        exp_q.push_back('{1'b0, {tg[2:0], idx[3:0], b[0]}, 8'h00});
        mdat[idx][v][b] = mem_img[{tg[2:0], idx[3:0], b[0]}];
      end
      mv[idx][v] = 1;
      md[idx][v] = 0;
      mt[idx][v] = tg[2:0];
      w = v;
    end
    ed = we ? d : mdat[idx][w][off];
    if (we) begin
      mdat[idx][w][off] = d;
      md[idx][w] = 1;
    end
    mvict[idx] = (w == 0) ? 1 : 0;

    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready while idle", req_ready, 1);
    busy = 1;
    req_valid = 1'b1;
    req_write = we;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!resp_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(resp_valid == 1'b1, rq, "response arrived", resp_valid, 1);
    chk(resp_hit == hit, rq, "hit flag", resp_hit, hit);
    chk(resp_rdata == ed, rq, "response data", resp_rdata, ed);
    if (hit) chk(n == 2, "R11", "hit latency in cycles", n, 2);
    chk(exp_q.size() == 0, rq, "memory transfers outstanding", exp_q.size(), 0);
    exp_q.delete();
    #2 busy = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    #1;
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R10", "no response after reset", resp_valid, 0);
    chk(mem_valid == 1'b0, "R10", "no memory request after reset", mem_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] ra;
    for (int i = 0; i < 256; i++) mem_img[i] = 8'(i * 37 + 11);
    model_clear();
    do_reset();

    access(0, 8'h00, 8'h00, "R10");   // cold miss
    access(0, 8'h01, 8'h00, "R3");    // other byte of the same line
    access(1, 8'h01, 8'hA5, "R4");    // write hit, dirty
    access(0, 8'h01, 8'h00, "R4");
    access(0, 8'h20, 8'h00, "R6");    // fills the invalid way
    access(0, 8'h00, 8'h00, "R2");    // still present
    access(0, 8'h40, 8'h00, "R8");    // clean victim, no write
    access(0, 8'h00, 8'h00, "R6");    // recency kept the used way
    access(0, 8'h02, 8'h00, "R1");    // other set
    access(1, 8'h1F, 8'h5A, "R9");    // write miss allocate
    access(0, 8'h1E, 8'h00, "R9");    // fetched neighbour intact
    access(0, 8'h1F, 8'h00, "R1");
    access(0, 8'h60, 8'h00, "R6");
    access(0, 8'h80, 8'h00, "R7");    // dirty victim written back
    access(0, 8'h01, 8'h00, "R7");    // written-back byte returns from memory
    access(1, 8'hBF, 8'hC3, "R9");
    access(0, 8'hBF, 8'h00, "R9");
    stall_mode = 1;
    access(0, 8'hDF, 8'h00, "R12");
    access(0, 8'hFF, 8'h00, "R12");
    access(1, 8'hFE, 8'h3E, "R12");

    for (int i = 0; i < 300; i++) begin
      stall_mode = (i % 50) >= 25;
      ra = {3'($urandom_range(0, 3)), 4'($urandom_range(0, 2)), 1'($urandom_range(0, 1))};
      access(1'($urandom_range(0, 1)), ra, 8'($urandom_range(0, 255)), "R6");
    end

    stall_mode = 0;
    access(0, 8'h00, 8'h00, "R2");
    access(0, 8'h00, 8'h00, "R3");
    do_reset();
    access(0, 8'h00, 8'h00, "R10");   // known line gone after reset

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule